// File: doc/BRIEF.md
# Shared-Memory Bank Conflict Arbiter

This block takes a single warp-wide access to a banked scratchpad and turns it into a short series of conflict-free service cycles. Every lane has a word address and an active flag. The low address bits select one of a set of equally sized banks. The remaining bits select the row inside that bank. In each service cycle a bank delivers at most one row. Lanes that ask for the same row of a bank share that cycle as a broadcast, so they do not conflict. Lanes that ask for different rows of one bank are spread over successive cycles.

A request is accepted with a valid/ready handshake. Service cycles follow back to back, each showing the lanes granted in it and, for every bank, whether it is used and which row it reads. The block also reports the conflict degree with each cycle. This is the largest number of different rows asked of any single bank, and it equals the number of service cycles spent. A done flag marks the last cycle. After that cycle the next request may enter.

Top module: `smem_bank_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `req_ready` is 1 and `grant_valid`, `done`, `grant_mask` and `bank_en` are all 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next cycle through the cycle that carries `done`. A request offered during that time is not taken, and it has no effect on the grants.
- R3: The bank of a lane is its address modulo BANKS, taken from the low log2(BANKS) bits. Its row is the address divided by BANKS, taken from the remaining upper bits. BANKS is a power of two of at least 2.
- R4: In every service cycle, `bank_en[b]` is 1 exactly when bank b serves a row. `bank_row` field b, at bits [b*ROW_W +: ROW_W], holds that row. All granted lanes of one bank carry the same address.
- R5: When every active lane maps to a different bank, the whole request is granted in a single cycle, whatever the order of lanes to banks.
- R6: Active lanes that share one address are granted in the same cycle as a broadcast, and together they count as one row.
- R7: Within a bank, each cycle serves the row of the lowest-numbered active lane that is still ungranted. It grants every ungranted active lane of that bank that asks for this row.
- R8: `degree` equals the largest number of distinct rows asked of any single bank by the active lanes. It is 1 when there is no conflict, and also when no lane is active.
- R9: The number of service cycles equals `degree`. `done` is 1 in the last of them and in no other cycle. Each active lane is granted exactly once.
- R10: Inactive lanes are never granted. A request with no active lane produces one service cycle with an empty `grant_mask` and `done` set.
- R11: The first service cycle directly follows the accepting edge, and all service cycles of a request are contiguous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Arbiter can take a request |
| req_active | input | LANES | Per-lane active flags |
| req_addr | input | LANES*ADDR_W | Word address of lane i at bits [i*ADDR_W +: ADDR_W] |
| grant_valid | output | 1 | This cycle is a service cycle |
| grant_mask | output | LANES | Lanes served in this cycle |
| bank_en | output | BANKS | Banks accessed in this cycle |
| bank_row | output | BANKS*ROW_W | Row chosen per bank, field b at [b*ROW_W +: ROW_W] |
| degree | output | DEG_W | Conflict degree of the request being served |
| done | output | 1 | Last service cycle of the request |

## Verification
The bench builds the arbiter with 8 lanes, 4 banks and 6-bit addresses. With these values a lane count twice the bank count is enough to put every lane into one bank. That brings the full 8-way serialization and the widest degree value within reach, and hand-worked grant sequences stay short. The small row field lets each grant pattern be written and checked by hand. Mixed cases combine broadcast and conflict in the same bank, include inactive lanes whose addresses would conflict if they counted, and offer a request while an earlier one is still being served.

// File: rtl/smem_arb_pkg.sv
package smem_arb_pkg;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_SERVE = 1'b1
    } arb_state_e;

    // Width needed to index n distinct items (at least one bit).
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/smem_degree_calc.sv
module smem_degree_calc
    import smem_arb_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 12,
    parameter int DEG_W  = 6,
    localparam int BANK_W = idx_bits(BANKS)
) (
    input  logic [LANES-1:0]        active,
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    output logic [DEG_W-1:0]        degree
);

    // first_use[j]: lane j is the lowest active lane carrying its address
    logic [LANES-1:0] first_use;
    logic [DEG_W-1:0] best;
    logic [DEG_W-1:0] cnt;

    always_comb begin
        first_use = '0;
        for (int j = 0; j < LANES; j++) begin
            first_use[j] = active[j];
            for (int k = 0; k < j; k++) begin
                if (active[k] &&
                    addr_flat[k*ADDR_W +: ADDR_W] == addr_flat[j*ADDR_W +: ADDR_W])
                    first_use[j] = 1'b0;
            end
        end
    end

    // distinct rows per bank = number of first uses in that bank
    always_comb begin
        best = '0;
        cnt  = '0;
        for (int i = 0; i < LANES; i++) begin
            cnt = '0;
            if (active[i]) begin
                for (int j = 0; j < LANES; j++) begin
                    if (first_use[j] &&
                        addr_flat[j*ADDR_W +: BANK_W] == addr_flat[i*ADDR_W +: BANK_W])
                        cnt = cnt + DEG_W'(1);
                end
                if (cnt > best)
                    best = cnt;
            end
        end
        degree = (best == '0) ? DEG_W'(1) : best;
    end

endmodule

// File: rtl/smem_bank_pick.sv
module smem_bank_pick
    import smem_arb_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 12,
    localparam int BANK_W = idx_bits(BANKS),
    localparam int ROW_W  = ADDR_W - BANK_W
) (
    input  logic [LANES-1:0]        pending,
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    output logic [LANES-1:0]        grant,
    output logic [BANKS-1:0]        bank_en,
    output logic [BANKS*ROW_W-1:0]  bank_row
);

    logic [LANES-1:0] lane_hits [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic             hit;
        logic [ROW_W-1:0] row;
        logic [LANES-1:0] hits;

        // leader = lowest pending lane of this bank; its row wins the cycle
        always_comb begin
            hit  = 1'b0;
            row  = '0;
            hits = '0;
            for (int l = 0; l < LANES; l++) begin
                if (!hit && pending[l] &&
                    addr_flat[l*ADDR_W +: BANK_W] == BANK_W'(b)) begin
                    hit = 1'b1;
                    row = addr_flat[l*ADDR_W+BANK_W +: ROW_W];
                end
            end
            for (int l = 0; l < LANES; l++) begin
                hits[l] = hit && pending[l] &&
                          addr_flat[l*ADDR_W +: BANK_W] == BANK_W'(b) &&
                          addr_flat[l*ADDR_W+BANK_W +: ROW_W] == row;
            end
        end

        assign lane_hits[b]                  = hits;
        assign bank_en[b]                    = hit;
        assign bank_row[b*ROW_W +: ROW_W]    = row;
    end

    always_comb begin
        grant = '0;
        for (int b = 0; b < BANKS; b++)
            grant = grant | lane_hits[b];
    end

endmodule

// File: rtl/smem_bank_arbiter.sv
module smem_bank_arbiter
    import smem_arb_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 12,
    localparam int BANK_W = idx_bits(BANKS),
    localparam int ROW_W  = ADDR_W - BANK_W,
    localparam int DEG_W  = idx_bits(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES-1:0]        req_active,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    output logic                    grant_valid,
    output logic [LANES-1:0]        grant_mask,
    output logic [BANKS-1:0]        bank_en,
    output logic [BANKS*ROW_W-1:0]  bank_row,
    output logic [DEG_W-1:0]        degree,
    output logic                    done
);

    arb_state_e                state_q;
    logic [LANES-1:0]          pending_q;
    logic [LANES*ADDR_W-1:0]   addr_q;
    logic [DEG_W-1:0]          degree_q;
    logic [DEG_W-1:0]          degree_in;
    logic [LANES-1:0]          pick_grant;
    logic [BANKS-1:0]          pick_en;
    logic [BANKS*ROW_W-1:0]    pick_row;
    logic                      accept;

    smem_degree_calc #(
        .LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .DEG_W(DEG_W)
    ) u_degree (
        .active    (req_active),
        .addr_flat (req_addr),
        .degree    (degree_in)
    );

    smem_bank_pick #(
        .LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W)
    ) u_pick (
        .pending   (pending_q),
        .addr_flat (addr_q),
        .grant     (pick_grant),
        .bank_en   (pick_en),
        .bank_row  (pick_row)
    );

    assign req_ready   = (state_q == ARB_IDLE);
    assign accept      = req_valid && req_ready;
    assign grant_valid = (state_q == ARB_SERVE);
    assign grant_mask  = grant_valid ? pick_grant : '0;
    assign bank_en     = grant_valid ? pick_en : '0;
    assign bank_row    = grant_valid ? pick_row : '0;
    assign degree      = degree_q;
    assign done        = grant_valid && ((pending_q & ~pick_grant) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ARB_IDLE;
            pending_q <= '0;
            addr_q    <= '0;
            degree_q  <= '0;
        end else begin
            case (state_q)
                ARB_IDLE: begin
                    if (accept) begin
                        addr_q    <= req_addr;
                        pending_q <= req_active;
                        degree_q  <= degree_in;
                        state_q   <= ARB_SERVE;
                    end
                end
                ARB_SERVE: begin
                    pending_q <= pending_q & ~pick_grant;
                    if (done)
                        state_q <= ARB_IDLE;
                end
                default: state_q <= ARB_IDLE;
            endcase
        end
    end

    // ---------------- checks ----------------
    logic [DEG_W-1:0] served_q;

    always_ff @(posedge clk) begin
        if (rst || accept)
            served_q <= '0;
        else if (grant_valid)
            served_q <= served_q + DEG_W'(1);
    end

    assert_cycles_match_degree_R9: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && done) |-> (served_q + DEG_W'(1) == degree_q));

    assert_no_early_finish_R9: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !done) |-> (served_q + DEG_W'(1) < degree_q));

    assert_grant_only_pending_R10: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> ((grant_mask & ~pending_q) == '0));

    assert_progress_R7: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && pending_q != '0) |-> (grant_mask != '0));

    assert_serve_follows_accept_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> grant_valid);

    assert_ready_after_done_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready);

    always_ff @(posedge clk) begin
        if (!rst && grant_valid) begin
            for (int i = 0; i < LANES; i++) begin
                for (int j = i + 1; j < LANES; j++) begin
                    if (grant_mask[i] && grant_mask[j] &&
                        addr_q[i*ADDR_W +: BANK_W] == addr_q[j*ADDR_W +: BANK_W])
                        assert_one_word_per_bank_R4: assert (
                            addr_q[i*ADDR_W +: ADDR_W] == addr_q[j*ADDR_W +: ADDR_W]);
                end
            end
        end
    end

endmodule

// File: tb/smem_bank_arbiter_test.sv
`timescale 1ns/1ps
module smem_bank_arbiter_test;

    localparam int LANES  = 8;
    localparam int BANKS  = 4;
    localparam int ADDR_W = 6;
    localparam int ROW_W  = 4;
    localparam int DEG_W  = 4;
    localparam int NVEC   = 8;

    typedef struct packed {
        logic [7:0]  act;
        logic [47:0] addr;   // {lane7 .. lane0}
        logic [3:0]  deg;
        logic [63:0] grants; // byte k = grant mask of service cycle k
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        // R5: four lanes, four different banks, inactive lanes aliasing bank 0
        '{8'h0F, {6'd0,6'd0,6'd0,6'd0,6'd0,6'd3,6'd2,6'd1}, 4'd1, 64'h0F},
        // R6: full broadcast of one address
        '{8'hFF, {6'd5,6'd5,6'd5,6'd5,6'd5,6'd5,6'd5,6'd5}, 4'd1, 64'hFF},
        // R7: four rows in bank 0
        '{8'h0F, {6'd0,6'd0,6'd0,6'd0,6'd12,6'd8,6'd4,6'd0}, 4'd4, 64'h08040201},
        // R6 R7 R8: broadcast mixed with conflicts
        '{8'hFF, {6'd4,6'd2,6'd9,6'd5,6'd1,6'd0,6'd4,6'd0}, 4'd3, 64'h20924D},
        // R10: inactive lanes would add rows if counted
        '{8'hA5, {6'd3,6'd3,6'd15,6'd0,6'd11,6'd7,6'd7,6'd3}, 4'd3, 64'h200481},
        // R10: nothing active
        '{8'h00, {6'd1,6'd2,6'd3,6'd4,6'd5,6'd6,6'd7,6'd8}, 4'd1, 64'h00},
        // R8 R9: all lanes in bank 2, eight rows
        '{8'hFF, {6'd30,6'd26,6'd22,6'd18,6'd14,6'd10,6'd6,6'd2}, 4'd8, 64'h8040201008040201},
        // R7: leader is lane 0 even though its row is higher
        '{8'hFF, {6'd7,6'd6,6'd5,6'd3,6'd2,6'd1,6'd0,6'd4}, 4'd2, 64'hE21D}
    };

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic [LANES-1:0]        req_active = '0;
    logic [LANES*ADDR_W-1:0] req_addr = '0;
    logic                    grant_valid;
    logic [LANES-1:0]        grant_mask;
    logic [BANKS-1:0]        bank_en;
    logic [BANKS*ROW_W-1:0]  bank_row;
    logic [DEG_W-1:0]        degree;
    logic                    done;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    smem_bank_arbiter #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W)) uut (
        .clk, .rst, .req_valid, .req_ready, .req_active, .req_addr,
        .grant_valid, .grant_mask, .bank_en, .bank_row, .degree, .done
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // offer a request at a negedge; returns after the accepting edge (+1ns)
    task automatic offer(input logic [7:0] act, input logic [47:0] addr);
        @(negedge clk);
        req_valid  = 1'b1;
        req_active = act;
        req_addr   = addr;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic serve_and_check(input vec_t v, input int idx);
        for (int k = 0; k < int'(v.deg); k++) begin
            @(negedge clk);
            check(grant_valid == 1'b1, "R11", $sformatf("v%0d c%0d grant_valid", idx, k),
                  64'(grant_valid), 64'd1);
            check(grant_mask == v.grants[k*8 +: 8], "R7",
                  $sformatf("v%0d c%0d grant_mask", idx, k),
                  64'(grant_mask), 64'(v.grants[k*8 +: 8]));
            check(degree == v.deg, "R8", $sformatf("v%0d degree", idx),
                  64'(degree), 64'(v.deg));
            check(done == (k == int'(v.deg) - 1), "R9", $sformatf("v%0d c%0d done", idx, k),
                  64'(done), 64'(k == int'(v.deg) - 1));
        end
        @(negedge clk);
        check(grant_valid == 1'b0 && req_ready == 1'b1, "R9",
              $sformatf("v%0d idle after last cycle", idx),
              64'({grant_valid, req_ready}), 64'b01);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1: state during and right after reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready == 1'b1 && grant_valid == 1'b0 && done == 1'b0, "R1",
              "ready/valid/done in reset", 64'({req_ready, grant_valid, done}), 64'b100);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && grant_valid == 1'b0 && done == 1'b0 &&
              grant_mask == '0 && bank_en == '0, "R1", "after reset",
              64'({req_ready, grant_valid, done, grant_mask, bank_en}),
              64'({1'b1, 1'b0, 1'b0, 8'h00, 4'h0}));

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            offer(VECS[i].act, VECS[i].addr);
            serve_and_check(VECS[i], i);
        end

        // R3 R4: bank mapping and per-bank row; lane0=13 -> bank1 row3, lane1=22 -> bank2 row5
        offer(8'h03, {6'd0,6'd0,6'd0,6'd0,6'd0,6'd0,6'd22,6'd13});
        @(negedge clk);
        check(grant_mask == 8'h03, "R5", "two banks one cycle", 64'(grant_mask), 64'h03);
        check(bank_en == 4'b0110, "R4", "bank_en", 64'(bank_en), 64'b0110);
        check(bank_row == 16'h0530, "R3", "bank_row fields", 64'(bank_row), 64'h0530);
        check(done == 1'b1, "R9", "single cycle done", 64'(done), 64'd1);
        @(negedge clk);

        // R4: second cycle of the mixed vector shows rows 1 in banks 0 and 1
        offer(VECS[3].act, VECS[3].addr);
        @(negedge clk);
        check(bank_en == 4'b0111 && bank_row == 16'h0000, "R4", "mixed cycle0 banks",
              64'({bank_en, bank_row}), 64'({4'b0111, 16'h0000}));
        @(negedge clk);
        check(bank_en == 4'b0011 && bank_row == 16'h0011, "R4", "mixed cycle1 banks",
              64'({bank_en, bank_row}), 64'({4'b0011, 16'h0011}));
        @(negedge clk);
        @(negedge clk);

        // R2: second request held during a 4-cycle service is ignored until done
        @(negedge clk);
        req_valid  = 1'b1;
        req_active = VECS[2].act;
        req_addr   = VECS[2].addr;
        @(posedge clk);
        #1;
        req_active = VECS[1].act;
        req_addr   = VECS[1].addr;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(req_ready == 1'b0, "R2", $sformatf("ready low c%0d", k),
                  64'(req_ready), 64'd0);
            check(grant_mask == VECS[2].grants[k*8 +: 8], "R2",
                  $sformatf("held request no effect c%0d", k),
                  64'(grant_mask), 64'(VECS[2].grants[k*8 +: 8]));
        end
        @(negedge clk);
        check(req_ready == 1'b1, "R2", "ready back after done", 64'(req_ready), 64'd1);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        @(negedge clk);
        check(grant_mask == 8'hFF && degree == 4'd1 && done == 1'b1, "R2",
              "held request taken after done",
              64'({grant_mask, degree, done}), 64'({8'hFF, 4'd1, 1'b1}));
        @(negedge clk);
        check(grant_valid == 1'b0, "R9", "idle after broadcast", 64'(grant_valid), 64'd0);

        summary();
        $finish;
    end

endmodule